// File: doc/BRIEF.md
# Receive Frame Status Trailer

This block sits between a receive MAC front end and the path that writes received frames to memory. Frame bytes arrive with valid, last and per-byte error indications and go straight through to a byte stream with valid/ready handshaking. When a frame ends, the block closes it with a fixed four-byte trailer. Downstream logic can then find the length and condition of each frame in the data itself, with no separate status register to read.

The trailer starts with a 16-bit status word, low byte first. Bits 11:0 of that word hold the number of frame bytes that were forwarded, and bits 15:12 hold four error flags. The third trailer byte is a runt-frame event count and the fourth is a receive-collision event count. Both are sampled from inputs when the frame's last byte is taken. An optional stripping mode removes padding from short length-typed frames. The stripped bytes are taken from the input but are neither forwarded nor counted.

Top module: `rx_status_trailer`

## Requirements
- R1: While a frame is being received, each input byte that is not stripped appears unchanged on `out_data`, in arrival order. It is transferred only when `out_ready` is high, and `out_last` stays low during frame data.
- R2: After a frame's last byte is accepted, exactly four trailer bytes follow in this order: status low byte, status high byte, runt count, collision count. `out_last` is high on the fourth trailer byte only.
- R3: Status bits 11:0 equal the number of bytes of the frame that were forwarded on the output.
- R4: The byte count saturates at 4095 when a frame forwards more bytes than that.
- R5: Status bit 15 is the OR of `in_err[3]` (receive overrun) over all accepted bytes of the frame. Bit 14 is the same for `in_err[2]` (collision), bit 13 for `in_err[1]` (framing) and bit 12 for `in_err[0]` (FCS). The flags start clear for every new frame.
- R6: `in_ready` is low from the cycle after the last byte is accepted until the fourth trailer byte is taken.
- R7: With `strip_en` high, the length field is bytes 12 (high) and 13 (low) of the frame, counted from 0. If that field is below 46, bytes at index 14+length and beyond are accepted but neither forwarded nor counted. With `strip_en` low, or a field of 46 or more, every byte is forwarded.
- R8: The runt and collision trailer bytes carry the values of `runt_cnt` and `coll_cnt` at the cycle the frame's last byte is accepted. Later changes to those inputs do not alter them.
- R9: After reset, with no input valid, `out_valid` and `out_last` are low and no trailer is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strip_en | input | 1 | Enable padding removal on short length-typed frames |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err | input | 4 | Per-byte error flags: overrun, collision, framing, FCS |
| runt_cnt | input | 8 | Runt frame event count to report |
| coll_cnt | input | 8 | Receive collision event count to report |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte, frame data or trailer |
| out_last | output | 1 | High on the final trailer byte |

## Verification
Each fault has a visible effect at the ports. A byte counter that is off by one, or that fails to saturate, shows up in the status bytes at the end of the very frame it affects. A flag register that is not cleared shows in the status word of the next clean frame. A broken stripping comparison changes both the number of bytes forwarded and the count, so the data stream and the trailer drift out of step with the expected sequence. A control state that skips or repeats a trailer byte puts `out_last` on the wrong beat, or lets new frame data in too early, within four transfers.

// File: rtl/rx_status_trailer.sv
module rx_status_trailer #(
  parameter int HDR_LEN     = 14,
  parameter int MIN_PAYLOAD = 46
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strip_en,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic [3:0] in_err,
  input  logic [7:0] runt_cnt,
  input  logic [7:0] coll_cnt,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int CW   = 12;
  localparam int CMAX = (1 << CW) - 1;

  typedef enum logic [2:0] {S_DATA, S_LO, S_HI, S_RUNT, S_COLL} st_t;

  st_t           st;
  logic [CW-1:0] pos, cnt;
  logic [15:0]   lenf;
  logic [3:0]    flg;
  logic [7:0]    runt_q, coll_q;
  logic          drop, acc, fwd;
  logic [CW-1:0] cnt_nx, pos_nx;
  logic [3:0]    flg_nx;
  logic [15:0]   stat;

  wire in_data_st = (st == S_DATA);

  always_comb
    drop = strip_en && (32'(pos) >= HDR_LEN) && (32'(lenf) < MIN_PAYLOAD)
           && (32'(pos) >= HDR_LEN + 32'(lenf));

  assign in_ready = in_data_st && (out_ready || drop);
  assign acc      = in_valid && in_ready;
  assign fwd      = acc && !drop;
  assign cnt_nx   = (fwd && cnt != CW'(CMAX)) ? cnt + 1'b1 : cnt;
  assign pos_nx   = (pos != CW'(CMAX)) ? pos + 1'b1 : pos;
  assign flg_nx   = acc ? (flg | in_err) : flg;
  assign stat     = {flg, cnt};

  assign out_valid = in_data_st ? (in_valid && !drop) : 1'b1;
  assign out_last  = (st == S_COLL);

  always_comb begin
    case (st)
      S_LO:    out_data = stat[7:0];
      S_HI:    out_data = stat[15:8];
      S_RUNT:  out_data = runt_q;
      S_COLL:  out_data = coll_q;
      default: out_data = in_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_DATA;
      pos    <= '0;
      cnt    <= '0;
      lenf   <= '0;
      flg    <= '0;
      runt_q <= '0;
      coll_q <= '0;
    end else begin
      case (st)
        S_DATA: if (acc) begin
          pos <= pos_nx;
          cnt <= cnt_nx;
          flg <= flg_nx;
          if (pos == CW'(HDR_LEN - 2)) lenf[15:8] <= in_data;
          if (pos == CW'(HDR_LEN - 1)) lenf[7:0]  <= in_data;
          if (in_last) begin
            st     <= S_LO;
            runt_q <= runt_cnt;
            coll_q <= coll_cnt;
          end
        end
        S_LO:   if (out_ready) st <= S_HI;
        S_HI:   if (out_ready) st <= S_RUNT;
        S_RUNT: if (out_ready) st <= S_COLL;
        default: if (out_ready) begin
          st   <= S_DATA;
          pos  <= '0;
          cnt  <= '0;
          lenf <= '0;
          flg  <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_status_trailer_chk.sv
module rx_status_trailer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strip_en,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_last,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);
  logic       in_tr;
  logic [1:0] tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_tr <= 1'b0;
      tcnt  <= '0;
    end else if (in_tr) begin
      if (out_valid && out_ready) begin
        if (out_last) begin
          in_tr <= 1'b0;
          tcnt  <= '0;
        end else tcnt <= tcnt + 1'b1;
      end
    end else if (in_valid && in_ready && in_last) in_tr <= 1'b1;
  end

  a_r6_block_input_in_trailer: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  a_r2_last_on_fourth: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |-> (in_tr && tcnt == 2'd3));

  a_r2_trailer_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
    in_tr |-> (out_valid && !in_ready));

  a_r7_drop_needs_strip: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_valid) |-> strip_en);

  a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_tr && out_valid) |-> (in_valid && out_data == in_data && !out_last));
endmodule

bind rx_status_trailer rx_status_trailer_chk u_chk (.*);

// File: tb/test_rx_status_trailer.sv
`timescale 1ns/1ps
module test_rx_status_trailer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strip_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic [3:0] in_err = '0;
  logic [7:0] runt_cnt = '0;
  logic [7:0] coll_cnt = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_last;

  int errors = 0;
  int checks = 0;
  bit stall = 1'b0;
  bit done = 1'b0;

  logic [8:0] qd[$];
  string      qt[$];
  bit         qtr[$];
  logic [7:0] fb[$];
  logic [3:0] fe[$];

  always #4 clk = ~clk;

  rx_status_trailer i_rx_status_trailer (.*);

  task automatic push(input logic [7:0] d, input logic l, input string t, input bit tr);
    qd.push_back({l, d});
    qt.push_back(t);
    qtr.push_back(tr);
  endtask

  task automatic send(input bit strip, input string ctag);
    int n, len, nfwd, cnt;
    logic [3:0] fl;
    n = fb.size();
    len = (n >= 14) ? int'({fb[12], fb[13]}) : 0;
    nfwd = n;
    if (strip && n >= 14 && len < 46) nfwd = (14 + len < n) ? 14 + len : n;
    fl = '0;
    for (int i = 0; i < n; i++) fl |= fe[i];
    for (int i = 0; i < nfwd; i++) push(fb[i], 1'b0, strip ? "R7" : "R1", 1'b0);
    cnt = (nfwd > 4095) ? 4095 : nfwd;
    push(8'(cnt), 1'b0, ctag, 1'b1);
    push({fl, 4'(cnt >> 8)}, 1'b0, "R5", 1'b1);
    push(runt_cnt, 1'b0, "R8", 1'b1);
    push(coll_cnt, 1'b1, "R2 R8", 1'b1);
    strip_en = strip;
    for (int i = 0; i < n; i++) begin
      @(posedge clk) #1;
      in_valid = 1'b1;
      in_data  = fb[i];
      in_err   = fe[i];
      in_last  = (i == n - 1);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
    end
    @(posedge clk) #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_err   = '0;
    runt_cnt = ~runt_cnt;
    coll_cnt = ~coll_cnt;
  endtask

  task automatic make(input int n);
    fb.delete();
    fe.delete();
    for (int i = 0; i < n; i++) begin
      fb.push_back(8'(i * 7 + 3));
      fe.push_back(4'h0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk) #1;
      out_ready = stall ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        checks++;
        if (qd.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected output act=%h last=%b exp=none", out_data, out_last);
        end else begin
          if ({out_last, out_data} !== qd[0]) begin
            errors++;
            $display("FAIL %s: act=%b_%h exp=%b_%h", qt[0], out_last, out_data, qd[0][8], qd[0][7:0]);
          end
          if (qtr[0]) begin
            checks++;
            if (in_ready !== 1'b0) begin
              errors++;
              $display("FAIL R6: in_ready act=%b exp=0 during trailer", in_ready);
            end
          end
          void'(qd.pop_front());
          void'(qt.pop_front());
          void'(qtr.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=hung exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_last !== 1'b0) begin
      errors++;
      $display("FAIL R9: out_valid/out_last act=%b%b exp=00", out_valid, out_last);
    end

    runt_cnt = 8'h11; coll_cnt = 8'h22;
    make(20);
    send(1'b0, "R3");

    stall = 1'b1;
    runt_cnt = 8'h05; coll_cnt = 8'h09;
    make(64);
    fe[5] = 4'b1000;
    fe[63] = 4'b0001;
    send(1'b0, "R3");

    make(30);
    send(1'b0, "R5");

    make(60);
    fb[12] = 8'h00; fb[13] = 8'd10;
    fe[50] = 4'b0010;
    send(1'b1, "R7");

    make(60);
    fb[12] = 8'h00; fb[13] = 8'd10;
    send(1'b0, "R7");

    make(60);
    fb[12] = 8'h00; fb[13] = 8'd100;
    send(1'b1, "R7");

    make(8);
    send(1'b1, "R7");

    stall = 1'b0;
    make(4100);
    send(1'b0, "R4");

    stall = 1'b1;
    make(1);
    fe[0] = 4'b0110;
    send(1'b0, "R3");

    while (qd.size() != 0) @(posedge clk);
    repeat (5) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule